// File: doc/BRIEF.md
# Dual-Channel Serial Converter Input Register

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A slow serial clock carries a 24-bit word into a shift register. Two level-sensitive, active-low latch controls then copy the matching halves of that word into two holding registers. Each holding register is the code that drives one converter cell. The last stage of the shift register is brought out as a serial output, so several devices can share one bit stream in a chain.

All logic runs on a fast system clock. The serial clock, serial data and both latch inputs are brought into that clock domain through two-flop synchronizers. A shift happens when the synchronized serial clock shows a falling edge. The system clock must run at least four times faster than the serial clock.

An asynchronous active-low clear empties the shift register and puts both holding registers at midscale. The clear is released in step with the system clock.

Top module: `dual_dac_input_reg`

## Requirements
- R1: Each falling edge of `sclk` shifts `sdi` into bit 0 of the 24-bit shift register, and every older bit moves up one place. The first bit of a 24-bit word therefore ends in bit 23. After 24 shifts, bits [23:12] hold channel B's code and bits [11:0] hold channel A's code, each with its MSB first.
- R2: `sdo` always shows bit 23 of the shift register. After the shift register is loaded, further shifts bring the earlier bits out on `sdo` in the order they went in.
- R3: While `latch_a_n` is low, `code_a` follows shift-register bits [11:0]. When `latch_a_n` goes high, `code_a` keeps its last value.
- R4: While `latch_b_n` is low, `code_b` follows shift-register bits [23:12]. When `latch_b_n` goes high, `code_b` keeps its last value.
- R5: A pulse on one latch input leaves the other channel's code unchanged.
- R6: When both latch inputs are driven low together, both codes load from the same shift-register contents.
- R7: While `clr_n` is low, the shift register reads 0, `sdo` is 0, and both codes read 0x800 (midscale, only the MSB set).
- R8: If a latch goes low after a clear and no bits have been shifted in since, that channel's code becomes 0x000.
- R9: While `clr_n` is low, activity on `sclk` and on the latch inputs has no effect. Clear takes priority over shifting and latching.
- R10: A rising edge of `sclk` does not shift.
- R11: To refresh one channel, shift in 12 new bits and then pulse only that channel's latch. The channel's code then equals those 12 bits, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples `sclk` by at least 4x |
| clr_n | input | 1 | Asynchronous active-low clear, released in step with `clk` |
| sclk | input | 1 | Serial clock; a shift happens on each falling edge |
| sdi | input | 1 | Serial data input |
| latch_a_n | input | 1 | Active-low, transparent latch control for channel A |
| latch_b_n | input | 1 | Active-low, transparent latch control for channel B |
| sdo | output | 1 | Serial output taken from shift-register bit 23 |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |

## Verification
The assertions check the following on every system clock:
- each detected serial-clock fall moves the register up by exactly one bit;
- with no detected fall, the register holds;
- a synchronized low latch copies its half of the register;
- a synchronized high latch freezes its code;
- each release from clear starts from an empty register and midscale codes.

Other behaviour can only be shown by the bench scenarios, because it depends on the order of whole sequences at the pins:
- the MSB-first load order across a full 24-bit word;
- the order in which a chained device receives bits on `sdo`;
- the zero code loaded after a clear;
- a latch pulse that leaves the other channel untouched;
- serial-clock and latch activity that has no effect while clear is held.

// File: rtl/dual_dac_input_reg.sv
module dual_dac_input_reg #(
  parameter int CODE_W = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              latch_a_n,
  input  logic              latch_b_n,
  output logic              sdo,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  localparam int SR_W = 2 * CODE_W;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [SYNC_N-1:0] rst_q, sclk_q, sdi_q, la_q, lb_q;
  logic              sclk_prev;
  logic [SR_W-1:0]   sr;

  wire rst_i  = rst_q[SYNC_N-1];
  wire sclk_s = sclk_q[SYNC_N-1];
  wire sdi_s  = sdi_q[SYNC_N-1];
  wire la_s   = la_q[SYNC_N-1];
  wire lb_s   = lb_q[SYNC_N-1];
  wire fall   = sclk_prev & ~sclk_s;

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) rst_q <= '0;
    else        rst_q <= {rst_q[SYNC_N-2:0], 1'b1};

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) begin
      sclk_q    <= '0;
      sdi_q     <= '0;
      la_q      <= '1;
      lb_q      <= '1;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[SYNC_N-2:0], sclk};
      sdi_q     <= {sdi_q[SYNC_N-2:0], sdi};
      la_q      <= {la_q[SYNC_N-2:0], latch_a_n};
      lb_q      <= {lb_q[SYNC_N-2:0], latch_b_n};
      sclk_prev <= sclk_s;
    end

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n)              sr <= '0;
    else if (rst_i && fall)  sr <= {sr[SR_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) begin
      code_a <= MID;
      code_b <= MID;
    end else if (rst_i) begin
      if (!la_s) code_a <= sr[CODE_W-1:0];
      if (!lb_s) code_b <= sr[SR_W-1:CODE_W];
    end

  assign sdo = sr[SR_W-1];
endmodule

module dual_dac_input_reg_chk #(
  parameter int CODE_W = 12
) (
  input logic                clk,
  input logic                rst_i,
  input logic                fall,
  input logic                sdi_s,
  input logic                la_s,
  input logic                lb_s,
  input logic [2*CODE_W-1:0] sr,
  input logic [CODE_W-1:0]   code_a,
  input logic [CODE_W-1:0]   code_b
);
  localparam int SR_W = 2 * CODE_W;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  // R1
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    fall |=> (sr == {$past(sr[SR_W-2:0]), $past(sdi_s)}));
  // R10
  no_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !fall |=> $stable(sr));
  // R3
  latch_a_follow_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !la_s |=> (code_a == $past(sr[CODE_W-1:0])));
  // R3
  latch_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    la_s |=> $stable(code_a));
  // R4
  latch_b_follow_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !lb_s |=> (code_b == $past(sr[SR_W-1:CODE_W])));
  // R4
  latch_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    lb_s |=> $stable(code_b));
  // R7
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> (sr == '0 && code_a == MID && code_b == MID));
endmodule

bind dual_dac_input_reg dual_dac_input_reg_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .fall(fall), .sdi_s(sdi_s), .la_s(la_s), .lb_s(lb_s),
  .sr(sr), .code_a(code_a), .code_b(code_b));

// File: tb/dual_dac_input_reg_tb.sv
module dual_dac_input_reg_tb;
  logic clk = 0, clr_n = 0, sclk = 1, sdi = 0, la_n = 1, lb_n = 1;
  logic sdo;
  logic [11:0] code_a, code_b;
  logic [23:0] m_sr;
  logic [11:0] m_a, m_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_dac_input_reg u_dut (.clk(clk), .clr_n(clr_n), .sclk(sclk), .sdi(sdi),
    .latch_a_n(la_n), .latch_b_n(lb_n), .sdo(sdo), .code_a(code_a), .code_b(code_b));

  function automatic logic [23:0] shifted(logic [23:0] s, logic b);
    return {s[22:0], b};
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    sdi = b; sclk = 1; wt(6);
    sclk = 0; wt(6);
    m_sr = shifted(m_sr, b);
  endtask

  task automatic shift_word(logic [23:0] w, int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse(bit a, bit b);
    if (a) la_n = 0;
    if (b) lb_n = 0;
    wt(6);
    la_n = 1; lb_n = 1; wt(6);
    if (a) m_a = m_sr[11:0];
    if (b) m_b = m_sr[23:12];
  endtask

  task automatic check_all(string req);
    chk({req, " code_a"}, {12'h0, code_a}, {12'h0, m_a});
    chk({req, " code_b"}, {12'h0, code_b}, {12'h0, m_b});
    chk({req, " sdo"}, {23'h0, sdo}, {23'h0, m_sr[23]});
  endtask

  initial begin
    wt(200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    void'($urandom(32'h5eed));
    m_sr = '0; m_a = 12'h800; m_b = 12'h800;
    wt(4);
    check_all("R7 reset");
    clr_n = 1; wt(6);

    // R8: latch straight after clear gives zero
    pulse(1, 0);
    check_all("R8 zero after clear");

    // R1 R6: full word, both latches together
    shift_word(24'hABC123, 24);
    pulse(1, 1);
    check_all("R1 R6 word order");
    chk("R1 order", {12'h0, code_b}, 24'h000ABC);

    // R2: cascade output order
    for (int i = 0; i < 12; i++) begin
      chk("R2 sdo order", {23'h0, sdo}, {23'h0, m_sr[23]});
      shift_bit(1'b0);
    end

    // R10: rising edge alone does not shift
    sclk = 0; sdi = 1; wt(6); sclk = 1; wt(8);
    pulse(1, 1);
    check_all("R10 rise no shift");
    sclk = 1;

    // R11 R5: refresh A only with 12 bits
    shift_word(24'h000F5A, 12);
    pulse(1, 0);
    check_all("R11 R5 refresh A");
    chk("R11 code", {12'h0, code_a}, 24'h000F5A);
    shift_word(24'h0003C6, 12);
    pulse(0, 1);
    check_all("R5 refresh B only");

    // R3: transparency while held low
    la_n = 0; wt(6);
    for (int i = 0; i < 6; i++) begin
      shift_bit(i[0]);
      chk("R3 transparent", {12'h0, code_a}, {12'h0, m_sr[11:0]});
    end
    la_n = 1; wt(6); m_a = m_sr[11:0];
    shift_word(24'h000FFF, 12);
    check_all("R3 R4 frozen");
    // R4: transparency on B
    lb_n = 0; wt(6);
    shift_bit(1'b1);
    chk("R4 transparent", {12'h0, code_b}, {12'h0, m_sr[23:12]});
    lb_n = 1; wt(6); m_b = m_sr[23:12];

    // R7 R9: clear, then activity while held
    clr_n = 0; wt(2);
    m_sr = '0; m_a = 12'h800; m_b = 12'h800;
    check_all("R7 clear");
    sdi = 1; sclk = 1; wt(6); sclk = 0; wt(6);
    la_n = 0; lb_n = 0; wt(6); la_n = 1; lb_n = 1; wt(6);
    check_all("R9 ignored in clear");
    clr_n = 1; wt(6);
    check_all("R9 after release");
    pulse(0, 1);
    check_all("R8 zero B");

    // random mix
    for (int k = 0; k < 40; k++) begin
      w = 24'($urandom);
      shift_word(w, 24);
      chk("R1 random sdo", {23'h0, sdo}, {23'h0, w[23]});
      pulse(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      check_all("R5 R6 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule